// File: doc/BRIEF.md
# Edge-Coded Pulse Isolation Channel

This block models one channel of a digital isolator. The logic level does not cross the barrier as a level. The transmit side filters and synchronizes a sampled input. It sends a one-cycle "set" strobe when the filtered level rises and a one-cycle "clear" strobe when it falls. The receive side keeps a bistable output that these strobes flip.

The transmitter keeps the link alive while the input is quiet. After a stretch with no transmitted strobe it repeats the current level, then keeps repeating it at a shorter interval. When the input-side power-good flag drops, the transmitter goes silent. When the flag returns, it sends the current level on the very next edge. The receiver has a watchdog that drives the output high when strobes stop arriving. The receiver treats a simultaneous set and clear as a link fault, which it ignores and records in a sticky flag.

The two link wires are brought out on both sides. A normal instance ties `tx_set`/`tx_clr` to `rx_set`/`rx_clr`, and an integration can place any barrier model in between. Both halves share one clock and a synchronous active-high reset.

Top module: `iso_pulse_link`

## Requirements
- R1: A change of the filtered input produces exactly one one-cycle strobe: `tx_set` for a rise, `tx_clr` for a fall, never both in one cycle. With the link looped back, `dout` takes the new level on the (SYNC_STAGES + FILT_MIN + 1)-th rising edge after the edge that first samples the new `din` value.
- R2: The receiver output goes high the cycle after a lone `rx_set`, goes low the cycle after a lone `rx_clr`, and otherwise keeps its value (apart from R6).
- R3: An input excursion held for fewer than FILT_MIN sampled cycles produces no strobe. One held for FILT_MIN cycles does pass.
- R4: If no strobe has been sent for IDLE_FIRST cycles, the transmitter sends a strobe carrying the current level (`tx_set` if high, `tx_clr` if low).
- R5: After a refresh strobe, and while the input stays unchanged, further refresh strobes follow every REFRESH_GAP cycles.
- R6: If the receiver sees no lone set or clear for WD_LIMIT cycles, `dout` is forced high. The next lone strobe takes control of `dout` again at once.
- R7: While `src_pwr_ok` is low, no strobe is sent. With the link looped back, `dout` therefore ends up high through R6.
- R8: On the first rising clock edge at which `src_pwr_ok` is sampled high again, the transmitter sends a strobe carrying the current filtered level.
- R9: `rx_set` and `rx_clr` asserted together leave `dout` unchanged, do not restart the watchdog, and set `link_err`. Once set, `link_err` stays high until reset.
- R10: Reset drives `dout` high, both link outputs low, `link_err` low and both interval counters to zero. The first refresh therefore comes IDLE_FIRST cycles after the power-rise strobe that follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both sides |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Sampled logic input on the source side |
| src_pwr_ok | input | 1 | Source-side power-good flag |
| tx_set | output | 1 | Link strobe: level became or is high |
| tx_clr | output | 1 | Link strobe: level became or is low |
| rx_set | input | 1 | Received set strobe |
| rx_clr | input | 1 | Received clear strobe |
| dout | output | 1 | Bistable channel output, defaults high |
| link_err | output | 1 | Sticky flag for a simultaneous set and clear |

## Verification
With the default two-stage synchronizer and a filter of FILT_MIN cycles, a `din` change yields a strobe SYNC_STAGES+FILT_MIN edges after capture and a new `dout` one edge later. The bench samples one cycle before that point, expecting the old value and no strobe. It samples again at that point, expecting the strobe, and one cycle later, expecting the new output and the strobe gone. Refresh strobes are expected exactly IDLE_FIRST and REFRESH_GAP cycles after the previous strobe. The watchdog is expected to fire exactly WD_LIMIT cycles after an injected strobe, and the power-return strobe one edge after the flag rises. Every check is made mid-cycle, on the falling edge, and each is timed by counting registers from the stimulus edge.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  // Why the transmitter emits a strobe in a given cycle.
  typedef enum logic [1:0] {
    TXC_NONE    = 2'd0,
    TXC_EDGE    = 2'd1,
    TXC_REFRESH = 2'd2,
    TXC_POWER   = 2'd3
  } tx_cause_e;

  // Counter width able to hold values 0 .. span-1.
  function automatic int cnt_bits(input int span);
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

  // Larger of two interval lengths.
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iso_in_filter.sv
module iso_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MIN    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl
);
  import iso_link_pkg::*;

  logic [SYNC_STAGES-1:0] sync_r;
  logic                   sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r <= '0;
    end else begin
      sync_r[0] <= din;
      for (int i = 1; i < SYNC_STAGES; i++) sync_r[i] <= sync_r[i-1];
    end
  end

  assign sync_q = sync_r[SYNC_STAGES-1];

  generate
    if (FILT_MIN <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) lvl <= 1'b0;
        else     lvl <= sync_q;
      end
    end else begin : g_count
      localparam int CW = cnt_bits(FILT_MIN);
      localparam logic [CW-1:0] RUN_LAST = CW'(FILT_MIN - 1);
      logic [CW-1:0] run_cnt;
      logic          differs;
      assign differs = (sync_q != lvl);

      always_ff @(posedge clk) begin
        if (rst) begin
          lvl     <= 1'b0;
          run_cnt <= '0;
        end else if (differs) begin
          if (run_cnt == RUN_LAST) begin
            lvl     <= sync_q;
            run_cnt <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end else begin
          run_cnt <= '0;
        end
      end

      AST_FLT_RUN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_LAST); // R3
    end
  endgenerate

  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sync_q == lvl) |=> (lvl == $past(lvl))); // R3

endmodule

// File: rtl/iso_tx_encoder.sv
module iso_tx_encoder #(
  parameter int IDLE_FIRST  = 100,
  parameter int REFRESH_GAP = 85
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic pwr_ok,
  output logic tx_set,
  output logic tx_clr
);
  import iso_link_pkg::*;

  localparam int CW = cnt_bits(max_of(IDLE_FIRST, REFRESH_GAP));
  localparam logic [CW-1:0] FIRST_LAST = CW'(IDLE_FIRST - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(REFRESH_GAP - 1);

  logic          lvl_q;
  logic          pg_q;
  logic          repeating;
  logic [CW-1:0] idle_cnt;

  // Named events, visible to the assertions.
  logic      edge_seen;
  logic      pwr_rise;
  logic      refresh_due;
  tx_cause_e cause;

  assign edge_seen   = (lvl != lvl_q);
  assign pwr_rise    = pwr_ok & ~pg_q;
  assign refresh_due = (idle_cnt == (repeating ? GAP_LAST : FIRST_LAST));

  always_comb begin
    if (!pwr_ok)          cause = TXC_NONE;
    else if (pwr_rise)    cause = TXC_POWER;
    else if (edge_seen)   cause = TXC_EDGE;
    else if (refresh_due) cause = TXC_REFRESH;
    else                  cause = TXC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= 1'b0;
      pg_q      <= 1'b0;
      repeating <= 1'b0;
      idle_cnt  <= '0;
      tx_set    <= 1'b0;
      tx_clr    <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      pg_q   <= pwr_ok;
      tx_set <= (cause != TXC_NONE) &  lvl;
      tx_clr <= (cause != TXC_NONE) & ~lvl;
      case (cause)
        TXC_EDGE, TXC_POWER: begin
          idle_cnt  <= '0;
          repeating <= 1'b0;
        end
        TXC_REFRESH: begin
          idle_cnt  <= '0;
          repeating <= 1'b1;
        end
        default: begin
          if (!pwr_ok) begin
            idle_cnt  <= '0;
            repeating <= 1'b0;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(tx_set && tx_clr)); // R1

  AST_TX_EDGE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (cause == TXC_EDGE) |=> ((tx_set == $past(lvl)) && (tx_set != tx_clr))); // R1

  AST_TX_SILENT_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !(tx_set || tx_clr)); // R7

  AST_TX_POWER_STROBE: assert property (@(posedge clk) disable iff (rst)
    pwr_rise |=> (tx_set || tx_clr)); // R8

  AST_TX_IDLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= FIRST_LAST || idle_cnt <= GAP_LAST); // R5

endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder #(
  parameter int WD_LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic link_err
);
  import iso_link_pkg::*;

  localparam int WW = cnt_bits(WD_LIMIT);
  localparam logic [WW-1:0] WD_LAST = WW'(WD_LIMIT - 1);

  logic [WW-1:0] wd_cnt;

  // Named events, visible to the assertions.
  logic pulse_ok;
  logic pulse_both;
  logic wd_expired;

  assign pulse_ok   = rx_set ^ rx_clr;
  assign pulse_both = rx_set & rx_clr;
  assign wd_expired = (wd_cnt == WD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= 1'b1;
      wd_cnt   <= '0;
      link_err <= 1'b0;
    end else begin
      if (pulse_ok) begin
        dout   <= rx_set;
        wd_cnt <= '0;
      end else begin
        if (!wd_expired) wd_cnt <= wd_cnt + 1'b1;
        if (wd_expired)  dout   <= 1'b1;
      end
      if (pulse_both) link_err <= 1'b1;
    end
  end

  AST_RX_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rx_set && !rx_clr) |=> dout); // R2

  AST_RX_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
    (rx_clr && !rx_set) |=> !dout); // R2

  AST_RX_WD_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (wd_expired && !pulse_ok) |=> dout); // R6

  AST_RX_BOTH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (pulse_both && !wd_expired) |=> $stable(dout)); // R9

  AST_RX_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    link_err |=> link_err); // R9

endmodule

// File: rtl/iso_pulse_link.sv
module iso_pulse_link #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MIN    = 2,
  parameter int IDLE_FIRST  = 100,
  parameter int REFRESH_GAP = 85,
  parameter int WD_LIMIT    = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic src_pwr_ok,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic link_err
);

  logic flt_lvl;

  iso_in_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_MIN    (FILT_MIN)
  ) u_filter (
    .clk (clk),
    .rst (rst),
    .din (din),
    .lvl (flt_lvl)
  );

  iso_tx_encoder #(
    .IDLE_FIRST  (IDLE_FIRST),
    .REFRESH_GAP (REFRESH_GAP)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .lvl    (flt_lvl),
    .pwr_ok (src_pwr_ok),
    .tx_set (tx_set),
    .tx_clr (tx_clr)
  );

  iso_rx_decoder #(
    .WD_LIMIT (WD_LIMIT)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_set   (rx_set),
    .rx_clr   (rx_clr),
    .dout     (dout),
    .link_err (link_err)
  );

endmodule

// File: tb/sim_iso_pulse_link.sv
module sim_iso_pulse_link;
  localparam int SYNC  = 2;
  localparam int FM    = 3;
  localparam int FIRST = 24;
  localparam int GAP   = 19;
  localparam int WD    = 70;
  // Edges from capture to output: SYNC-1 more sync flops, FM filter
  // cycles, one transmit register, one receive register.
  localparam int LAT   = (SYNC - 1) + FM + 1 + 1;
  localparam logic [15:0] PAT = 16'b1011_0011_1010_0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic pwr = 1'b1;
  logic inj = 1'b0;
  logic inj_set = 1'b0;
  logic inj_clr = 1'b0;
  logic tx_set, tx_clr, dout, link_err;
  logic rx_set, rx_clr;

  int total = 0;
  int bad   = 0;
  int n_set = 0;
  int n_clr = 0;
  logic cur = 1'b0;

  always #4 clk = ~clk;

  assign rx_set = inj ? inj_set : tx_set;
  assign rx_clr = inj ? inj_clr : tx_clr;

  iso_pulse_link #(
    .SYNC_STAGES (SYNC),
    .FILT_MIN    (FM),
    .IDLE_FIRST  (FIRST),
    .REFRESH_GAP (GAP),
    .WD_LIMIT    (WD)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .src_pwr_ok (pwr),
    .tx_set     (tx_set),
    .tx_clr     (tx_clr),
    .rx_set     (rx_set),
    .rx_clr     (rx_clr),
    .dout       (dout),
    .link_err   (link_err)
  );

  // Strobe counters, sampled mid-cycle.
  always @(negedge clk) begin
    if (tx_set) n_set++;
    if (tx_clr) n_clr++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive_level(input logic nv, input int hold);
    logic old;
    int   b_new, b_opp;
    old   = cur;
    b_new = nv ? n_set : n_clr;
    b_opp = old ? n_clr : n_set;
    din   = nv;
    step(LAT - 1);
    if (nv != old) begin
      check("R1 no strobe before latency", (nv ? n_set : n_clr) - b_new, 0);
      step(1);
      check("R1 strobe at latency", int'(nv ? tx_set : tx_clr), 1);
      check("R2 output holds until strobe lands", int'(dout), int'(old));
      step(1);
      check("R1 strobe one cycle wide", int'(nv ? tx_set : tx_clr), 0);
      check("R1 output follows at latency", int'(dout), int'(nv));
    end else begin
      step(2);
      check("R1 repeated level gives no opposite strobe", (old ? n_clr : n_set) - b_opp, 0);
      check("R2 output holds on repeated level", int'(dout), int'(old));
    end
    cur = nv;
    if (hold > 0) step(hold);
  endtask

  task automatic glitch(input int w);
    int b_opp;
    b_opp = cur ? n_clr : n_set;
    din = ~cur;
    step(w);
    din = cur;
    step(LAT + FM + 4);
    if (w < FM)
      check("R3 short excursion rejected", (cur ? n_clr : n_set) - b_opp, 0);
    else
      check("R3 minimum-width excursion passes", (cur ? n_clr : n_set) - b_opp, 1);
    check("R3 output back at level", int'(dout), int'(cur));
  endtask

  initial begin : watchdog
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int base;
    #1;
    step(3);
    check("R10 reset output high", int'(dout), 1);
    check("R10 reset link quiet", int'(tx_set | tx_clr), 0);
    check("R10 reset error clear", int'(link_err), 0);

    rst = 1'b0;
    step(1);
    check("R8 power strobe after reset", int'(tx_clr), 1);
    check("R10 output still high", int'(dout), 1);
    step(1);
    check("R8 output takes low level", int'(dout), 0);
    base = n_set + n_clr;
    step(FIRST - 2);
    check("R10 no strobe before first refresh", n_set + n_clr - base, 0);
    step(1);
    check("R4 low refresh after idle", int'(tx_clr), 1);
    base = n_set + n_clr;
    step(GAP - 1);
    check("R5 no strobe inside gap", n_set + n_clr - base, 0);
    step(1);
    check("R5 repeated low refresh", int'(tx_clr), 1);

    for (int i = 0; i < 16; i++) drive_level(PAT[i], i % 4);

    for (int w = 1; w <= FM; w++) glitch(w);
    if (cur) drive_level(1'b0, 2);
    for (int w = 1; w <= FM; w++) glitch(w);

    drive_level(1'b1, 0);
    base = n_set + n_clr;
    step(FIRST - 2);
    check("R4 no strobe before high refresh", n_set + n_clr - base, 0);
    step(1);
    check("R4 high refresh after idle", int'(tx_set), 1);

    drive_level(1'b0, 3);
    inj = 1'b1;
    inj_clr = 1'b1;
    step(1);
    inj_clr = 1'b0;
    check("R2 injected clear", int'(dout), 0);
    step(WD - 1);
    check("R6 output held before timeout", int'(dout), 0);
    step(1);
    check("R6 timeout forces high", int'(dout), 1);
    inj_clr = 1'b1;
    step(1);
    inj_clr = 1'b0;
    check("R6 next strobe restores following", int'(dout), 0);

    inj_set = 1'b1;
    inj_clr = 1'b1;
    step(1);
    inj_set = 1'b0;
    inj_clr = 1'b0;
    check("R9 error flagged", int'(link_err), 1);
    check("R9 output unchanged by double strobe", int'(dout), 0);
    step(5);
    check("R9 error sticky", int'(link_err), 1);
    inj_set = 1'b1;
    step(1);
    inj_set = 1'b0;
    check("R2 injected set after error", int'(dout), 1);

    inj = 1'b0;
    step(FIRST + 2);
    check("R4 refresh returns output to level", int'(dout), 0);

    pwr = 1'b0;
    base = n_set + n_clr;
    din = 1'b1;
    step(12);
    din = 1'b0;
    step(WD + FIRST);
    check("R7 no strobes while unpowered", n_set + n_clr - base, 0);
    check("R7 output defaults high", int'(dout), 1);
    pwr = 1'b1;
    step(1);
    check("R8 state strobe on power return", int'(tx_clr), 1);
    step(1);
    check("R8 output matches input again", int'(dout), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule